// File: doc/BRIEF.md
# PCI Master Write Burst Sequencer

This block moves queued write commands onto a PCI bus as bus master. A command names a target space, a start address and a burst count in data phases. The data comes from a separate write-data FIFO. The block waits for enough data, then asks the master arbiter for the bus. Once granted, it offers one data phase per cycle and keeps bursting until the count is used up or the burst is cut short. Each command is carried on its own. Commands to adjacent addresses are never joined, and partial writes to one DWORD or QWORD are never merged.

A burst can end in several ways, and each has its own recovery. Reaching the count retires the command. A target disconnect, a target retry or an expired latency timer sends the block back to wait and ask for a continuation. The continuation starts at the address after the last accepted phase, with the count reduced by the phases done. If the data FIFO runs dry mid-burst, the block ends the burst the same way. It resumes only when the FIFO holds the refill threshold or the whole remainder, whichever is smaller. The threshold is 8 entries for a 32-bit bus and 16 for a 64-bit bus. A target abort or a master abort sets a sticky write-failure flag. The block then pops and discards the rest of that command's data without touching the bus.

Both feeds are valid/ready streams. A command moves when `cmd_valid` and `cmd_ready` are both high. A data entry leaves the FIFO when `wd_valid` and `wd_ready` are both high. The source must hold an entry stable while valid is high and ready is low. `cmd_ready` is high exactly when the block is idle. `wd_ready` is high only when an entry is consumed in that cycle.

Top module: `pcim_wr_seq`

## Requirements
- R1: Each command with a nonzero count gets its own bursts. A new command is taken only after the previous one has retired, so `bus_active` is low for at least one cycle between two commands. A command with count 0 is accepted and retired with no bus request.
- R2: Before the first burst of a command, and before every continuation, `arb_req` stays low until `wd_level` >= min(THRESH, remaining count). THRESH is 8 when DATA_W is 32 and 16 when DATA_W is 64. `arb_req` rises the cycle after the condition is seen.
- R3: `arb_req` stays high until a cycle with `arb_gnt` high. `bus_active` is high from the next cycle, and `arb_req` is then low.
- R4: While `bus_active` is high, a data phase completes in a cycle with `bus_dvalid` and `bus_ack` both high. That phase pops one data entry, and `bus_data` shows that entry. The next phase's `bus_addr` is higher by DATA_W/8. `bus_last` is high exactly when one phase remains.
- R5: With data present, no termination code and `bus_ack` held high, the burst continues phase after phase without dropping `bus_active`.
- R6: In a transfer cycle, `bus_term_code` 1 (target disconnect), 2 (target retry) or 3 (latency timer expired) ends the burst. A continuation follows under R2, at the next unwritten address with the reduced count. Code 0 means no termination. Codes 6 and 7 are treated as 0.
- R7: If `wd_valid` is low in a transfer cycle, the burst ends and a continuation follows under R2.
- R8: In a transfer cycle, `bus_term_code` 4 (target abort) or 5 (master abort) sets `irq_wfail` from the next cycle. The remaining entries of that command are then popped one per available entry through `wd_ready`. During this drain, `arb_req` and `bus_active` stay low. The block is idle after the last pop.
- R9: `irq_wfail` is 0 after reset. Once set, it stays set until a cycle with `wfail_clr` high clears it. A set in the same cycle wins over the clear.
- R10: If the final phase of a command completes in the same cycle as any termination code, the command retires and no continuation or drain follows.
- R11: A command moves only on `cmd_valid` and `cmd_ready`. A data entry moves only on `wd_valid` and `wd_ready`. `wd_ready` is never high while `wd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command stream valid |
| cmd_ready | output | 1 | Command stream ready (block idle) |
| cmd_space | input | 2 | Target space of the command |
| cmd_addr | input | ADDR_W | Start byte address |
| cmd_count | input | COUNT_W | Burst count in data phases |
| wd_valid | input | 1 | Write-data FIFO holds an entry |
| wd_ready | output | 1 | Pop the head data entry this cycle |
| wd_data | input | DATA_W | Head data entry |
| wd_level | input | LVL_W | Number of entries in the write-data FIFO |
| arb_req | output | 1 | Request to the master arbiter |
| arb_gnt | input | 1 | Grant from the master arbiter |
| bus_active | output | 1 | Burst in progress on the bus |
| bus_space | output | 2 | Space of the burst in progress |
| bus_addr | output | ADDR_W | Address of the current data phase |
| bus_data | output | DATA_W | Data of the current data phase |
| bus_dvalid | output | 1 | A data phase is offered |
| bus_last | output | 1 | Current phase is the final one of the command |
| bus_ack | input | 1 | Target accepts the offered data phase |
| bus_term_code | input | 3 | Burst termination cause, 0 = none |
| wfail_clr | input | 1 | Write-one-to-clear of the failure flag |
| irq_wfail | output | 1 | Sticky write-failure interrupt status |

## Verification
`cmd_ready`, `wd_ready`, `bus_dvalid`, `bus_last`, `bus_addr` and `bus_data` answer their inputs in the same cycle. A state change comes one clock after its cause. That covers `arb_req` rising after the FIFO level reaches the gate, `bus_active` after `arb_gnt`, the drop after a termination or underrun, and `irq_wfail` after an abort. The bench drives every input at the falling edge. It lets the design settle, then compares all outputs against a behavioural model. The model only advances on the values captured in the previous cycle, so every result is checked in the cycle it is due. Directed scenario-end checks then count the bursts seen and confirm the FIFO and flag state for each termination cause.

// File: rtl/pcim_wr_pkg.sv
package pcim_wr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_REQ   = 3'd2,
    ST_XFER  = 3'd3,
    ST_DRAIN = 3'd4
  } seq_state_t;

  localparam logic [2:0] TC_NONE   = 3'd0;
  localparam logic [2:0] TC_DISC   = 3'd1;
  localparam logic [2:0] TC_RETRY  = 3'd2;
  localparam logic [2:0] TC_LAT    = 3'd3;
  localparam logic [2:0] TC_TABORT = 3'd4;
  localparam logic [2:0] TC_MABORT = 3'd5;

  // refill threshold in bus-width entries before a burst may start
  function automatic int refill_thresh(input int data_w);
    return (data_w >= 64) ? 16 : 8;
  endfunction

endpackage

// File: rtl/pcim_wr_ptr.sv
module pcim_wr_ptr #(
  parameter int ADDR_W  = 32,
  parameter int COUNT_W = 8,
  parameter int BYTES   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [COUNT_W-1:0] load_count,
  input  logic               step,
  output logic [ADDR_W-1:0]  addr,
  output logic [COUNT_W-1:0] rem,
  output logic               rem_one
);

  localparam logic [ADDR_W-1:0]  ADDR_STEP = ADDR_W'(BYTES);
  localparam logic [COUNT_W-1:0] ONE       = COUNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
      rem  <= '0;
    end else if (load) begin
      addr <= load_addr;
      rem  <= load_count;
    end else if (step) begin
      addr <= addr + ADDR_STEP;
      rem  <= rem - ONE;
    end
  end

  assign rem_one = (rem == ONE);

endmodule

// File: rtl/pcim_wr_gate.sv
module pcim_wr_gate #(
  parameter int COUNT_W = 8,
  parameter int LVL_W   = 6,
  parameter int THRESH  = 8
) (
  input  logic [LVL_W-1:0]   level,
  input  logic [COUNT_W-1:0] rem,
  output logic               ok
);

  localparam int CW = ((COUNT_W > LVL_W) ? COUNT_W : LVL_W) + 1;
  localparam logic [CW-1:0] THR = CW'(THRESH);

  logic [CW-1:0] lvl_x;
  logic [CW-1:0] rem_x;
  logic [CW-1:0] need;

  always_comb begin
    lvl_x = CW'(level);
    rem_x = CW'(rem);
    need  = (rem_x < THR) ? rem_x : THR;
    ok    = (lvl_x >= need);
  end

endmodule

// File: rtl/pcim_wr_status.sv
module pcim_wr_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);

endmodule

// File: rtl/pcim_wr_seq.sv
module pcim_wr_seq
  import pcim_wr_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int COUNT_W = 8,
  parameter int LVL_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic [1:0]         cmd_space,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [COUNT_W-1:0] cmd_count,
  input  logic               wd_valid,
  output logic               wd_ready,
  input  logic [DATA_W-1:0]  wd_data,
  input  logic [LVL_W-1:0]   wd_level,
  output logic               arb_req,
  input  logic               arb_gnt,
  output logic               bus_active,
  output logic [1:0]         bus_space,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_data,
  output logic               bus_dvalid,
  output logic               bus_last,
  input  logic               bus_ack,
  input  logic [2:0]         bus_term_code,
  input  logic               wfail_clr,
  output logic               irq_wfail
);

  localparam int BYTES  = DATA_W / 8;
  localparam int THRESH = refill_thresh(DATA_W);

  seq_state_t state, nxt;
  logic [1:0] space_q;
  logic [ADDR_W-1:0] addr;
  logic [COUNT_W-1:0] rem;
  logic rem_one, gate_ok;
  logic load, phase, drain_pop, is_abort, is_cont, fail_set;

  always_comb begin
    is_abort  = (bus_term_code == TC_TABORT) || (bus_term_code == TC_MABORT);
    is_cont   = (bus_term_code == TC_DISC) || (bus_term_code == TC_RETRY) ||
                (bus_term_code == TC_LAT);
    cmd_ready = (state == ST_IDLE);
    load      = cmd_ready && cmd_valid && (cmd_count != '0);
    phase     = (state == ST_XFER) && wd_valid && bus_ack;
    drain_pop = (state == ST_DRAIN) && wd_valid;
    wd_ready  = phase || drain_pop;
    fail_set  = (state == ST_XFER) && is_abort && !(phase && rem_one);
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (load) nxt = ST_WAIT;
      ST_WAIT:  if (gate_ok) nxt = ST_REQ;
      ST_REQ:   if (arb_gnt) nxt = ST_XFER;
      ST_XFER: begin
        if (phase && rem_one)        nxt = ST_IDLE;
        else if (is_abort)           nxt = ST_DRAIN;
        else if (is_cont || !wd_valid) nxt = ST_WAIT;
      end
      ST_DRAIN: if (drain_pop && rem_one) nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      space_q <= '0;
    end else begin
      state <= nxt;
      if (load) space_q <= cmd_space;
    end
  end

  pcim_wr_ptr #(.ADDR_W(ADDR_W), .COUNT_W(COUNT_W), .BYTES(BYTES)) u_ptr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_addr(cmd_addr),
    .load_count(cmd_count), .step(wd_ready), .addr(addr), .rem(rem),
    .rem_one(rem_one)
  );

  pcim_wr_gate #(.COUNT_W(COUNT_W), .LVL_W(LVL_W), .THRESH(THRESH)) u_gate (
    .level(wd_level), .rem(rem), .ok(gate_ok)
  );

  pcim_wr_status u_status (
    .clk(clk), .rst_n(rst_n), .set(fail_set), .clr(wfail_clr),
    .flag(irq_wfail)
  );

  assign arb_req    = (state == ST_REQ);
  assign bus_active = (state == ST_XFER);
  assign bus_space  = space_q;
  assign bus_addr   = addr;
  assign bus_data   = wd_data;
  assign bus_dvalid = bus_active && wd_valid;
  assign bus_last   = bus_active && rem_one;

  assert_no_pop_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> wd_valid);

  assert_gate_before_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_req) |-> $past(gate_ok));

  assert_grant_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_req && arb_gnt) |=> (bus_active && !arb_req));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dvalid && bus_ack && !bus_last && bus_term_code == TC_NONE)
      |=> (bus_active && bus_addr == $past(bus_addr) + ADDR_W'(BYTES)));

  assert_drain_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN) |-> (!arb_req && !bus_active));

  assert_final_retires_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_dvalid && bus_ack && bus_last) |=> (cmd_ready && !irq_wfail || cmd_ready));

endmodule

// File: tb/tb_pcim_wr_seq.sv
module tb_pcim_wr_seq;

  typedef struct packed {
    logic [1:0]  sp;
    logic [31:0] a;
    logic [7:0]  n;
  } tcmd_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid, cmd_ready, wd_valid, wd_ready, arb_req, arb_gnt;
  logic bus_active, bus_dvalid, bus_last, bus_ack, wfail_clr, irq_wfail;
  logic [1:0] cmd_space, bus_space;
  logic [31:0] cmd_addr, bus_addr, wd_data, bus_data;
  logic [7:0] cmd_count;
  logic [5:0] wd_level;
  logic [2:0] bus_term_code;

  always #4 clk = ~clk;

  pcim_wr_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_space(cmd_space), .cmd_addr(cmd_addr), .cmd_count(cmd_count),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .wd_level(wd_level), .arb_req(arb_req), .arb_gnt(arb_gnt),
    .bus_active(bus_active), .bus_space(bus_space), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_dvalid(bus_dvalid), .bus_last(bus_last),
    .bus_ack(bus_ack), .bus_term_code(bus_term_code), .wfail_clr(wfail_clr),
    .irq_wfail(irq_wfail)
  );

  int checks = 0, failures = 0, cyc = 0, bursts = 0;
  tcmd_t cq[$], cstage[$];
  logic [31:0] dq[$], dstage[$];
  logic [31:0] data_seq = 32'hA000_0000;
  int push_rate = 16;
  int term_at = -1, tb_ph = 0;
  logic [2:0] term_code = 3'd0;
  logic term_ack = 1'b0, clr_req = 1'b0, prev_act = 1'b0;

  // reference model state
  int m_mode = 0, m_rem = 0;
  logic [31:0] m_addr = 0;
  logic [1:0] m_space = 0;
  logic m_wfail = 0;
  // captured cycle values
  logic c_phase = 0, c_dpop = 0, c_cfire = 0, c_gnt = 0, c_clr = 0;
  logic [2:0] c_term = 0;
  int c_level = 0;
  tcmd_t c_cmd;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, got, exp);
    end
  endtask

  task automatic model_step();
    int thr;
    if (c_clr) m_wfail = 1'b0;
    case (m_mode)
      0: if (c_cfire && c_cmd.n != 0) begin
           m_addr = c_cmd.a; m_rem = c_cmd.n; m_space = c_cmd.sp; m_mode = 1;
         end
      1: begin
           thr = (m_rem < 8) ? m_rem : 8;
           if (c_level >= thr) m_mode = 2;
         end
      2: if (c_gnt) m_mode = 3;
      3: begin
           if (c_phase) begin m_addr += 4; m_rem--; end
           if (c_phase && m_rem == 0) m_mode = 0;
           else if (c_term == 4 || c_term == 5) begin m_wfail = 1'b1; m_mode = 4; end
           else if (c_term == 1 || c_term == 2 || c_term == 3) m_mode = 1;
           else if (c_level == 0) m_mode = 1;
         end
      4: if (c_dpop) begin
           m_rem--; m_addr += 4;
           if (m_rem == 0) m_mode = 0;
         end
      default: m_mode = 0;
    endcase
  endtask

  // per-cycle driver, model and comparison
  initial begin
    logic e_cr, e_req, e_act, e_last, e_dv, e_wdr, ph;
    cmd_valid = 0; cmd_space = 0; cmd_addr = 0; cmd_count = 0;
    wd_valid = 0; wd_data = 0; wd_level = 0; arb_gnt = 0; bus_ack = 0;
    bus_term_code = 0; wfail_clr = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        m_mode = 0; m_rem = 0; m_addr = 0; m_wfail = 0;
        c_phase = 0; c_dpop = 0; c_cfire = 0; c_gnt = 0; c_clr = 0; c_term = 0;
      end else begin
        model_step();
        if (c_phase) tb_ph++;
        if ((c_phase || c_dpop) && dq.size() > 0) void'(dq.pop_front());
        if (c_cfire && cq.size() > 0) void'(cq.pop_front());
      end
      for (int i = 0; i < push_rate && dstage.size() > 0; i++) dq.push_back(dstage.pop_front());
      while (cstage.size() > 0) cq.push_back(cstage.pop_front());
      cmd_valid = (cq.size() > 0);
      if (cq.size() > 0) begin
        cmd_space = cq[0].sp; cmd_addr = cq[0].a; cmd_count = cq[0].n;
      end else begin
        cmd_space = 0; cmd_addr = 0; cmd_count = 0;
      end
      wd_valid = (dq.size() > 0);
      wd_level = 6'(dq.size());
      wd_data  = (dq.size() > 0) ? dq[0] : 32'h0;
      wfail_clr = clr_req;
      #1;
      arb_gnt = arb_req && cyc[0];
      if (!bus_active) tb_ph = 0;
      if (bus_active && term_at >= 0 && tb_ph == term_at) begin
        bus_term_code = term_code; bus_ack = term_ack;
      end else begin
        bus_term_code = 0; bus_ack = bus_active;
      end
      #1;
      if (rst_n) begin
        e_cr = (m_mode == 0); e_req = (m_mode == 2); e_act = (m_mode == 3);
        e_last = e_act && (m_rem == 1);
        e_dv = e_act && (dq.size() > 0);
        ph = e_dv && bus_ack;
        e_wdr = ph || (m_mode == 4 && dq.size() > 0);
        chk("R11 cmd_ready", cmd_ready, e_cr);
        chk("R3 arb_req", arb_req, e_req);
        chk("R5 bus_active", bus_active, e_act);
        chk("R4 bus_last", bus_last, e_last);
        chk("R4 bus_dvalid", bus_dvalid, e_dv);
        chk("R11 wd_ready", wd_ready, e_wdr);
        chk("R9 irq_wfail", irq_wfail, m_wfail);
        if (e_act) begin
          chk("R6 bus_addr", bus_addr, m_addr);
          chk("R1 bus_space", bus_space, m_space);
          if (dq.size() > 0) chk("R4 bus_data", bus_data, dq[0]);
        end
        if (bus_active && !prev_act) bursts++;
        prev_act = bus_active;
        c_phase = ph; c_dpop = (m_mode == 4 && dq.size() > 0);
        c_cfire = e_cr && (cq.size() > 0);
        if (cq.size() > 0) c_cmd = cq[0];
        c_gnt = arb_gnt; c_term = bus_term_code; c_clr = wfail_clr;
        c_level = dq.size();
        if (bus_term_code != 0) term_at = -1;
        clr_req = 1'b0;
      end
    end
  end

  task automatic push_data(input int n);
    for (int i = 0; i < n; i++) begin dstage.push_back(data_seq); data_seq++; end
  endtask

  task automatic push_cmd(input logic [1:0] sp, input logic [31:0] a, input logic [7:0] n);
    tcmd_t t;
    t.sp = sp; t.a = a; t.n = n;
    cstage.push_back(t);
  endtask

  task automatic wait_idle();
    int stable = 0;
    for (int i = 0; i < 2000 && stable < 3; i++) begin
      @(negedge clk); #3;
      if (cstage.size() == 0 && cq.size() == 0 && m_mode == 0 && !bus_active) stable++;
      else stable = 0;
    end
  endtask

  task automatic arm_term(input int at, input logic [2:0] code, input logic ack);
    term_at = at; term_code = code; term_ack = ack;
  endtask

  initial begin
    int b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    chk("R9 reset irq_wfail", irq_wfail, 1'b0);
    chk("R11 reset cmd_ready", cmd_ready, 1'b1);
    chk("R3 reset arb_req", arb_req, 1'b0);

    // R4/R5: plain burst
    b0 = bursts; push_data(4); push_cmd(2'd3, 32'h100, 8'd4); wait_idle();
    chk("R5 single burst count", bursts - b0, 1);

    // R1: adjacent commands stay separate; zero count never bursts
    b0 = bursts; push_data(6); push_cmd(2'd3, 32'h200, 8'd3); push_cmd(2'd3, 32'h20C, 8'd3);
    wait_idle();
    chk("R1 adjacent commands not merged", bursts - b0, 2);
    b0 = bursts; push_cmd(2'd1, 32'h300, 8'd0); wait_idle();
    chk("R1 zero count no burst", bursts - b0, 0);

    // R2: threshold gate holds the request
    b0 = bursts; push_data(7); push_cmd(2'd3, 32'h400, 8'd20);
    repeat (20) @(negedge clk); #3;
    chk("R2 below threshold no request", arb_req, 1'b0);
    chk("R2 below threshold no burst", bursts - b0, 0);
    push_data(13); wait_idle();
    chk("R2 burst after threshold", bursts - b0, 1);

    // R7: underrun then refill of the remainder
    b0 = bursts; push_data(8); push_cmd(2'd3, 32'h500, 8'd12);
    repeat (30) @(negedge clk);
    push_data(4); wait_idle();
    chk("R7 underrun continuation", bursts - b0, 2);

    // R6: disconnect, retry and latency expiry
    b0 = bursts; arm_term(3, 3'd1, 1'b0); push_data(6); push_cmd(2'd3, 32'h600, 8'd6); wait_idle();
    chk("R6 disconnect continuation", bursts - b0, 2);
    b0 = bursts; arm_term(0, 3'd2, 1'b0); push_data(4); push_cmd(2'd2, 32'h700, 8'd4); wait_idle();
    chk("R6 retry continuation", bursts - b0, 2);
    b0 = bursts; arm_term(2, 3'd3, 1'b0); push_data(5); push_cmd(2'd0, 32'h800, 8'd5); wait_idle();
    chk("R6 latency continuation", bursts - b0, 2);

    // R8: target abort drains the rest
    b0 = bursts; arm_term(2, 3'd4, 1'b0); push_data(10); push_cmd(2'd3, 32'h900, 8'd10); wait_idle();
    chk("R8 target abort one burst", bursts - b0, 1);
    chk("R8 target abort drained", dq.size(), 0);
    chk("R8 target abort flag", irq_wfail, 1'b1);
    clr_req = 1'b1; repeat (2) @(negedge clk); #3;
    chk("R9 clear flag", irq_wfail, 1'b0);

    // R8: master abort
    b0 = bursts; arm_term(1, 3'd5, 1'b0); push_data(5); push_cmd(2'd3, 32'hA00, 8'd5); wait_idle();
    chk("R8 master abort one burst", bursts - b0, 1);
    chk("R8 master abort drained", dq.size(), 0);
    chk("R9 flag held", irq_wfail, 1'b1);

    // R10: termination on final phase retires command
    b0 = bursts; arm_term(2, 3'd1, 1'b1); push_data(3); push_cmd(2'd3, 32'hB00, 8'd3); wait_idle();
    chk("R10 final phase retires", bursts - b0, 1);
    b0 = bursts; arm_term(1, 3'd4, 1'b1); push_data(2); push_cmd(2'd3, 32'hC00, 8'd2);
    clr_req = 1'b1; wait_idle();
    chk("R10 abort on final phase no flag", irq_wfail, 1'b0);
    chk("R10 abort on final phase one burst", bursts - b0, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired cycle %0d actual=hung expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule